// File: doc/BRIEF.md
# Stack, Call-Return and Software-Interrupt Sequencer

This block handles every stack transfer for a small 16-bit processor. It owns the stack segment and stack pointer registers. Each stack word address is formed as segment plus pointer. The block steps through multi-word transfers one 16-bit memory word per clock. A single command carries out a push, a pop, a subroutine call, a return or a software-interrupt entry.

The stack grows toward higher addresses. A push stores the word at the current pointer and then advances the pointer by two. A pop moves the pointer back by two and then reads. A call saves the caller's code segment and instruction pointer. It then continues at the operand offset within the same code segment. A return restores both words in the reverse order. An interrupt entry saves the same two words and then fetches a new code segment from a vector table. That table sits in the last 512 bytes of the address space. Entry always resumes at instruction pointer zero.

The decoder presents a command only while `busy` is low. It takes the new code segment and instruction pointer, or the popped word, in the cycle `done` pulses. A pop or return that would go below the stack base is refused. The refusal pulses `err_underflow` together with `done` and leaves all state as it was.

Top module: `sst_stack_seq`

## Requirements
- R1: A push (cmd_op = 1) writes cmd_arg at address SS+SP and then adds 2 to SP; `done` is high in the second cycle after the command is accepted.
- R2: A pop (cmd_op = 2) with SP ≠ 0 first subtracts 2 from SP, then reads the word at SS+SP into pop_data; `done` is high in the second cycle after acceptance.
- R3: A pop while SP = 0 makes no memory access and leaves SP, SS, cs_out, ip_out and pop_data unchanged; `err_underflow` and `done` are both high in the cycle after acceptance.
- R4: A call (cmd_op = 3) writes cs_in at SS+SP, then writes ip_in at SS+SP+2, and leaves SP increased by 4. It sets cs_out = cs_in and ip_out = cmd_arg, and `done` is high in the third cycle after acceptance.
- R5: A return (cmd_op = 4) reads ip_out from SS+SP−2 and then reads cs_out from SS+SP−4, leaving SP decreased by 4; `done` is high in the third cycle after acceptance.
- R6: A return while SP < 4 is refused in the same way as R3: no memory access, no state change, and `err_underflow` with `done` one cycle after acceptance.
- R7: An interrupt (cmd_op = 5) with vector v = cmd_arg[7:0] pushes cs_in and then ip_in as a call does. It then sets cs_out to the word at address MEM_BYTES − 512 + 2·v and sets ip_out = 0. cmd_arg[15:8] has no effect, and `done` is high in the fourth cycle after acceptance.
- R8: A command with cmd_op of 0, 6 or 7 is ignored, and so is any command presented while `busy` is high. Ignored commands cause no memory access, no SP change and no `done`.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after a multi-cycle command is accepted until the cycle in which `done` rises, and `busy` is low while `done` is high.
- R10: After reset, SP = 0, SS equals its reset parameter, and cs_out, ip_out and pop_data are 0. `busy`, `done`, `err_underflow` and `mem_req` are all low. SS never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 1 push, 2 pop, 3 call, 4 return, 5 interrupt |
| cmd_arg | input | DW | Push value, call offset or interrupt vector |
| cs_in | input | DW | Current code segment |
| ip_in | input | DW | Current (return) instruction pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_underflow | output | 1 | Refused pop or return, with done |
| cs_out | output | DW | New code segment |
| ip_out | output | DW | New instruction pointer |
| pop_data | output | DW | Last popped word |
| sp_out | output | DW | Stack pointer |
| ss_out | output | DW | Stack segment |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write word |
| mem_rdata | input | DW | Read word, valid in the same cycle |

## Verification
A wrong pointer step or a wrong address offset shows up within a single push–pop pair. The word read back differs from the word pushed, or the pointer value exposed at the port drifts from the running count of pushes minus pops. A state machine that skips or repeats a step shows up at once as a wrong `done` latency. It also shows up as a saved code segment or instruction pointer landing at the wrong stack slot. A bad vector index shows up in the cs_out of the same interrupt. Sweeping all 256 vectors and a deep push/pop run exposes each of these within a few cycles of the faulty command.

// File: rtl/sst_pkg.sv
package sst_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_PUSH = 3'd1,
      OP_POP  = 3'd2,
      OP_CALL = 3'd3,
      OP_RET  = 3'd4,
      OP_INT  = 3'd5
   } sst_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_A,
      ST_WR_B,
      ST_RD_A,
      ST_RD_B,
      ST_VEC
   } sst_state_e;

endpackage

// File: rtl/sst_addr_gen.sv
module sst_addr_gen #(
   parameter int DW = 16,
   parameter int AW = 16
) (
   input  logic [DW-1:0] seg,
   input  logic [DW-1:0] off,
   output logic [AW-1:0] addr
);
   generate
      if (AW >= DW) begin : g_wide
         assign addr = AW'(seg) + AW'(off);
      end else begin : g_narrow
         assign addr = seg[AW-1:0] + off[AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/sst_sp_reg.sv
module sst_sp_reg #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_up,
   input  logic          step_down,
   output logic [DW-1:0] sp
);
   localparam logic [DW-1:0] STEP = DW'(2);

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp <= '0;
      else if (step_up)
         sp <= sp + STEP;
      else if (step_down)
         sp <= sp - STEP;
   end
endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl
   import sst_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [DW-1:0] cmd_arg,
   input  logic [DW-1:0] cs_in,
   input  logic [DW-1:0] ip_in,
   input  logic [DW-1:0] sp,
   input  logic [DW-1:0] rdata,
   output logic          req,
   output logic          we,
   output logic          use_vec,
   output logic          rd_step,
   output logic [DW-1:0] wdata,
   output logic [DW-1:0] arg_q,
   output logic          sp_up,
   output logic          sp_down,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [DW-1:0] cs_out,
   output logic [DW-1:0] ip_out,
   output logic [DW-1:0] pop_data
);
   sst_state_e    state;
   sst_op_e       op_q;
   logic [DW-1:0] cs_q;
   logic [DW-1:0] ip_q;
   logic          accept;
   logic          sp_empty;
   logic          sp_below_pair;

   assign accept        = cmd_valid && (state == ST_IDLE);
   assign sp_empty      = (sp == '0);
   assign sp_below_pair = (sp < DW'(4));

   always_comb begin
      req     = 1'b0;
      we      = 1'b0;
      use_vec = 1'b0;
      rd_step = 1'b0;
      sp_up   = 1'b0;
      sp_down = 1'b0;
      wdata   = '0;
      unique case (state)
         ST_WR_A: begin
            req   = 1'b1;
            we    = 1'b1;
            sp_up = 1'b1;
            wdata = (op_q == OP_PUSH) ? arg_q : cs_q;
         end
         ST_WR_B: begin
            req   = 1'b1;
            we    = 1'b1;
            sp_up = 1'b1;
            wdata = ip_q;
         end
         ST_RD_A, ST_RD_B: begin
            req     = 1'b1;
            rd_step = 1'b1;
            sp_down = 1'b1;
         end
         ST_VEC: begin
            req     = 1'b1;
            use_vec = 1'b1;
         end
         default: ;
      endcase
   end

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_q     <= OP_NONE;
         arg_q    <= '0;
         cs_q     <= '0;
         ip_q     <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         cs_out   <= '0;
         ip_out   <= '0;
         pop_data <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  arg_q <= cmd_arg;
                  cs_q  <= cs_in;
                  ip_q  <= ip_in;
                  unique case (cmd_op)
                     OP_PUSH: begin
                        op_q  <= OP_PUSH;
                        state <= ST_WR_A;
                     end
                     OP_CALL: begin
                        op_q  <= OP_CALL;
                        state <= ST_WR_A;
                     end
                     OP_INT: begin
                        op_q  <= OP_INT;
                        state <= ST_WR_A;
                     end
                     OP_POP: begin
                        op_q <= OP_POP;
                        if (sp_empty) begin
                           done <= 1'b1;
                           err  <= 1'b1;
                        end else begin
                           state <= ST_RD_A;
                        end
                     end
                     OP_RET: begin
                        op_q <= OP_RET;
                        if (sp_below_pair) begin
                           done <= 1'b1;
                           err  <= 1'b1;
                        end else begin
                           state <= ST_RD_A;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ST_WR_A: begin
               if (op_q == OP_PUSH) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  state <= ST_WR_B;
               end
            end
            ST_WR_B: begin
               if (op_q == OP_INT) begin
                  state <= ST_VEC;
               end else begin
                  cs_out <= cs_q;
                  ip_out <= arg_q;
                  state  <= ST_IDLE;
                  done   <= 1'b1;
               end
            end
            ST_VEC: begin
               cs_out <= rdata;
               ip_out <= '0;
               state  <= ST_IDLE;
               done   <= 1'b1;
            end
            ST_RD_A: begin
               if (op_q == OP_POP) begin
                  pop_data <= rdata;
                  state    <= ST_IDLE;
                  done     <= 1'b1;
               end else begin
                  ip_out <= rdata;
                  state  <= ST_RD_B;
               end
            end
            ST_RD_B: begin
               cs_out <= rdata;
               state  <= ST_IDLE;
               done   <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sst_stack_seq.sv
module sst_stack_seq #(
   parameter int              DW          = 16,
   parameter int              AW          = 16,
   parameter int              VEC_W       = 8,
   parameter int              TABLE_BYTES = 512,
   parameter logic [DW-1:0]   SS_RST      = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [DW-1:0] cmd_arg,
   input  logic [DW-1:0] cs_in,
   input  logic [DW-1:0] ip_in,
   output logic          busy,
   output logic          done,
   output logic          err_underflow,
   output logic [DW-1:0] cs_out,
   output logic [DW-1:0] ip_out,
   output logic [DW-1:0] pop_data,
   output logic [DW-1:0] sp_out,
   output logic [DW-1:0] ss_out,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int unsigned   MEM_BYTES = 32'd1 << AW;
   localparam logic [AW-1:0] VEC_BASE  = AW'(MEM_BYTES - 32'(TABLE_BYTES));

   generate
      if (AW < 2 || AW > 30) begin : g_bad_aw
         $error("sst_stack_seq: AW out of range");
      end
      if (VEC_W < 1 || VEC_W >= DW || VEC_W >= AW) begin : g_bad_vw
         $error("sst_stack_seq: VEC_W out of range");
      end
      if ((2 << VEC_W) > TABLE_BYTES || TABLE_BYTES > (1 << AW)) begin : g_bad_tab
         $error("sst_stack_seq: vector table does not fit");
      end
      if (SS_RST[0] != 1'b0) begin : g_bad_ss
         $error("sst_stack_seq: stack segment must be word aligned");
      end
   endgenerate

   logic          rq, wr, use_vec, rd_step, sp_up, sp_down;
   logic [DW-1:0] wdata, arg_q, sp;
   logic [DW-1:0] stk_off;
   logic [AW-1:0] stk_addr, vec_addr;
   logic [AW-1:0] vec_off;

   sst_ctrl #(.DW(DW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .cmd_arg  (cmd_arg),
      .cs_in    (cs_in),
      .ip_in    (ip_in),
      .sp       (sp),
      .rdata    (mem_rdata),
      .req      (rq),
      .we       (wr),
      .use_vec  (use_vec),
      .rd_step  (rd_step),
      .wdata    (wdata),
      .arg_q    (arg_q),
      .sp_up    (sp_up),
      .sp_down  (sp_down),
      .busy     (busy),
      .done     (done),
      .err      (err_underflow),
      .cs_out   (cs_out),
      .ip_out   (ip_out),
      .pop_data (pop_data)
   );

   sst_sp_reg #(.DW(DW)) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_up  (sp_up),
      .step_down(sp_down),
      .sp       (sp)
   );

   assign stk_off = rd_step ? (sp - DW'(2)) : sp;
   assign vec_off = AW'({arg_q[VEC_W-1:0], 1'b0});

   sst_addr_gen #(.DW(DW), .AW(AW)) u_stk_addr (
      .seg (SS_RST),
      .off (stk_off),
      .addr(stk_addr)
   );

   sst_addr_gen #(.DW(AW), .AW(AW)) u_vec_addr (
      .seg (VEC_BASE),
      .off (vec_off),
      .addr(vec_addr)
   );

   assign mem_req   = rq;
   assign mem_we    = wr;
   assign mem_addr  = use_vec ? vec_addr : stk_addr;
   assign mem_wdata = wdata;
   assign sp_out    = sp;
   assign ss_out    = SS_RST;
endmodule

// File: rtl/sst_stack_seq_chk.sv
module sst_stack_seq_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err_underflow,
   input logic [DW-1:0] sp_out,
   input logic [DW-1:0] ss_out,
   input logic          mem_req,
   input logic          mem_we
);
   // R9
   busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_underflow |-> (done && $stable(sp_out)));

   // R1
   write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> (sp_out == $past(sp_out) + DW'(2)));

   // R1
   sp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sp_out[0]);

   // R8
   access_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R10
   ss_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ss_out));
endmodule

bind sst_stack_seq sst_stack_seq_chk #(.DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .err_underflow(err_underflow),
   .sp_out       (sp_out),
   .ss_out       (ss_out),
   .mem_req      (mem_req),
   .mem_we       (mem_we)
);

// File: tb/tb_sst_stack_seq.sv
`timescale 1ns/1ps
module tb_sst_stack_seq;
   localparam int            DW    = 16;
   localparam int            AW    = 16;
   localparam logic [15:0]   SS    = 16'h1000;
   localparam int            VBASE = 65536 - 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [15:0]   cmd_arg = '0, cs_in = '0, ip_in = '0;
   logic          busy, done, err_underflow, mem_req, mem_we;
   logic [15:0]   cs_out, ip_out, pop_data, sp_out, ss_out, mem_wdata, mem_rdata;
   logic [15:0]   mem_addr;

   logic [15:0]   mem [0:32767];
   int            n_chk = 0, n_bad = 0, n_acc = 0;

   always #5 clk = ~clk;

   sst_stack_seq #(.DW(DW), .AW(AW), .VEC_W(8), .TABLE_BYTES(512), .SS_RST(SS)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_arg(cmd_arg), .cs_in(cs_in), .ip_in(ip_in), .busy(busy), .done(done),
      .err_underflow(err_underflow), .cs_out(cs_out), .ip_out(ip_out),
      .pop_data(pop_data), .sp_out(sp_out), .ss_out(ss_out), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[15:1]];
   always @(posedge clk) begin
      if (mem_req) n_acc <= n_acc + 1;
      if (mem_req && mem_we) mem[mem_addr[15:1]] <= mem_wdata;
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] rdw(input int byte_addr);
      return mem[(byte_addr & 16'hFFFF) >> 1];
   endfunction

   task automatic run(input logic [2:0] op, input logic [15:0] arg, input logic [15:0] c,
                      input logic [15:0] i, output int lat);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cs_in = c; ip_in = i;
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 1;
      while (!done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
   endtask

   function automatic logic [15:0] pval(input int k);
      return 16'hA000 ^ 16'(k * 16'h0123);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int lat, acc0, spx;
      logic [15:0] c0, i0;
      for (int a = 0; a < 32768; a++) mem[a] = 16'(a * 5 + 3);
      for (int v = 0; v < 256; v++) mem[(VBASE + 2*v) >> 1] = 16'h5000 + 16'(v * 7);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 sp", sp_out, 0);
      chk("R10 ss", ss_out, SS);
      chk("R10 outs", {cs_out, ip_out}, 0);
      chk("R10 pop_data", pop_data, 0);
      chk("R10 flags", {busy, done, err_underflow, mem_req}, 0);

      // R3 pop at empty
      acc0 = n_acc;
      run(3'd2, 16'h0, 16'h0, 16'h0, lat);
      chk("R3 latency", lat, 1);
      chk("R3 err", err_underflow, 1);
      chk("R3 sp", sp_out, 0);
      chk("R3 no access", n_acc - acc0, 0);
      chk("R3 outs", {cs_out, ip_out}, 0);
      @(negedge clk);
      chk("R9 done pulse", {done, err_underflow}, 0);

      // R6 return at empty
      run(3'd4, 16'h0, 16'h0, 16'h0, lat);
      chk("R6 err empty", {err_underflow, 16'(lat)}, {1'b1, 16'd1});

      // R1 push sweep
      for (int k = 0; k < 40; k++) begin
         run(3'd1, pval(k), 16'h0, 16'h0, lat);
         chk("R1 latency", lat, 2);
         chk("R1 sp", sp_out, 16'(2*(k+1)));
         chk("R1 word", rdw(SS + 2*k), pval(k));
         chk("R1 no err", err_underflow, 0);
      end
      // R2 pop sweep
      for (int k = 39; k >= 0; k--) begin
         run(3'd2, 16'h0, 16'h0, 16'h0, lat);
         chk("R2 latency", lat, 2);
         chk("R2 data", pop_data, pval(k));
         chk("R2 sp", sp_out, 16'(2*k));
      end

      // R6 return with one word on stack
      run(3'd1, 16'h7777, 16'h0, 16'h0, lat);
      acc0 = n_acc;
      run(3'd4, 16'h0, 16'h0, 16'h0, lat);
      chk("R6 err", {err_underflow, 16'(lat)}, {1'b1, 16'd1});
      chk("R6 sp", sp_out, 2);
      chk("R6 no access", n_acc - acc0, 0);
      chk("R6 outs", {cs_out, ip_out}, 0);
      run(3'd2, 16'h0, 16'h0, 16'h0, lat);
      chk("R2 single", pop_data, 16'h7777);

      // R8 illegal opcodes
      for (int op = 0; op < 8; op++) begin
         if (op == 0 || op == 6 || op == 7) begin
            acc0 = n_acc;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = 16'hFFFF;
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R8 no done", {done, busy}, 0);
            repeat (3) @(negedge clk);
            chk("R8 no access", n_acc - acc0, 0);
            chk("R8 sp", sp_out, 0);
         end
      end

      // R8 command while busy, R9 busy window
      acc0 = n_acc;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd3; cmd_arg = 16'h0AAA; cs_in = 16'h0123; ip_in = 16'h0456;
      @(negedge clk);
      chk("R9 busy", {busy, done}, 2'b10);
      cmd_op = 3'd1; cmd_arg = 16'hDEAD;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9 busy 2", {busy, done}, 2'b10);
      @(negedge clk);
      chk("R9 done end", {busy, done}, 2'b01);
      chk("R8 busy ignored sp", sp_out, 4);
      chk("R8 busy ignored acc", n_acc - acc0, 2);
      repeat (3) @(negedge clk);
      chk("R8 no second seq", {sp_out, 1'b0, done}, {16'd4, 2'b00});
      run(3'd4, 16'h0, 16'h0, 16'h0, lat);
      chk("R5 ret busy case", {cs_out, ip_out}, {16'h0123, 16'h0456});

      // R4 call sweep then R5 return sweep
      for (int j = 0; j < 8; j++) begin
         spx = 4*j;
         run(3'd3, 16'h0100 + 16'(j*3), 16'h0300 + 16'(j*16), 16'h0040 + 16'(j), lat);
         chk("R4 latency", lat, 3);
         chk("R4 cs", cs_out, 16'h0300 + 16'(j*16));
         chk("R4 ip", ip_out, 16'h0100 + 16'(j*3));
         chk("R4 saved cs", rdw(SS + spx), 16'h0300 + 16'(j*16));
         chk("R4 saved ip", rdw(SS + spx + 2), 16'h0040 + 16'(j));
         chk("R4 sp", sp_out, 16'(spx + 4));
      end
      for (int j = 7; j >= 0; j--) begin
         run(3'd4, 16'h0, 16'h0, 16'h0, lat);
         chk("R5 latency", lat, 3);
         chk("R5 ip", ip_out, 16'h0040 + 16'(j));
         chk("R5 cs", cs_out, 16'h0300 + 16'(j*16));
         chk("R5 sp", sp_out, 16'(4*j));
      end

      // R7 full vector sweep, upper arg bits set
      for (int v = 0; v < 256; v++) begin
         c0 = 16'h2000 + 16'(v);
         i0 = 16'h3000 + 16'(v * 2);
         run(3'd5, {8'h5A ^ 8'(v), 8'(v)}, c0, i0, lat);
         chk("R7 latency", lat, 4);
         chk("R7 cs", cs_out, 16'h5000 + 16'(v * 7));
         chk("R7 ip", ip_out, 0);
         chk("R7 saved", {rdw(SS), rdw(SS + 2)}, {c0, i0});
         chk("R7 sp", sp_out, 4);
         run(3'd4, 16'h0, 16'h0, 16'h0, lat);
         chk("R5 after int", {cs_out, ip_out}, {c0, i0});
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule